// File: doc/BRIEF.md
# ADC Result Dual-Mode Output Port

This block sits between a converter core and the package pads. It presents each 16-bit conversion result on a shared pad bus. The result goes out either as a parallel word or as a serial stream. A pad-select input picks between the two. In parallel mode, every data pad drives the held result word. In serial mode, only the lowest four data pads keep driving. Three of the other pads are read back as mode inputs:
- clock source (internal master or external slave),
- framing-pulse polarity,
- serial clock inversion.

The remaining pads are released.

A coding input selects straight binary or two's complement output. Two's complement is made by inverting the MSB. A one-cycle result strobe latches a new word. In serial mode the strobe also starts a frame. The frame shifts 16 bits MSB first under a framing pulse. In master mode the block makes the serial clock by dividing the system clock. In slave mode it synchronizes an external clock and shifts on its edges. A strobe that arrives while a frame is running never disturbs that frame. The newest word is sent in the frame that follows.

Top module: `adc_result_port`

## Requirements
- R1: With `bin_sel_i` high the word is output unchanged (straight binary). With it low, bit 15 is inverted (two's complement). This applies to the parallel word and to every serial frame, which uses the coding in force when the frame is loaded.
- R2: After reset the held word is 0. With `ser_sel_i` low, `data_o` shows the coded held word. A strobe on `result_valid_i` updates it at the next clock edge.
- R3: `data_oe_o[3:0]` are always 1. `data_oe_o[15:4]` are 1 in parallel mode and 0 in serial mode.
- R4: Without a strobe, the held word and `data_o` stay unchanged whatever `result_i` does.
- R5: In serial mode with `pad_in_i[0]` low (master), `sclk_oe_o` is 1. The serial clock toggles only while a frame is active, once every `CLK_DIV` system cycles starting from its idle level. In non-inverted terms a frame is 16 low-then-high periods, ending low.
- R6: Serial data leaves MSB first. The first bit appears with the frame start. Each following bit appears on a falling edge of the non-inverted serial clock, so every bit is stable around the rising edge. A frame carries exactly 16 bits. `sdout_o` is 0 when no frame is active.
- R7: `sync_o` is asserted for exactly the length of a frame. With `pad_in_i[1]` low it is active high; with `pad_in_i[1]` high it is active low.
- R8: `pad_in_i[2]` high inverts the serial clock in both master and slave modes. In master mode `sclk_o` idles high; in slave mode the falling edge of `sclk_i` acts as the rising one.
- R9: In serial mode with `pad_in_i[0]` high (slave), `sclk_oe_o` is 0. The data advances one bit on each falling edge of the synchronized, polarity-corrected `sclk_i` that follows a rising edge within the frame. The frame closes after the 16th such falling edge.
- R10: A strobe during a frame, including one on the frame's closing edge, changes neither that frame's bits nor its length. After one idle cycle a new frame starts, carrying the latest held word.
- R11: Dropping `ser_sel_i` aborts any frame. From the next edge on, `sdout_o` is 0, the framing pulse is inactive and no frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| result_i | input | 16 | Conversion result from the core |
| result_valid_i | input | 1 | One-cycle strobe: latch `result_i` |
| ser_sel_i | input | 1 | 0 parallel, 1 serial |
| bin_sel_i | input | 1 | 1 straight binary, 0 two's complement |
| pad_in_i | input | 3 | Pad readback of data bits 6..4: [0] external clock, [1] active-low sync, [2] inverted SCLK |
| sclk_i | input | 1 | External serial clock (slave mode) |
| data_o | output | 16 | Data pad output values |
| data_oe_o | output | 16 | Per-pad output enable |
| sclk_o | output | 1 | Serial clock pad output |
| sclk_oe_o | output | 1 | Serial clock pad output enable |
| sync_o | output | 1 | Framing pulse |
| sdout_o | output | 1 | Serial data |

## Verification
The interesting collision is a new result strobe landing in the same cycle as the closing falling edge of a running frame. Here the latch, the frame end and the start of the next frame all meet. The bench places one strobe mid-frame and another exactly on the 64th cycle after a frame start. A reference model run per clock then expects three things:
- the running frame finishes untouched;
- one idle cycle follows;
- the next frame carries the latest word.

A second overlap is a mode drop in the middle of a frame. This is judged by the serial pins going quiet at the very next edge.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef struct packed {
    logic serial;
    logic slave;
    logic sync_low;
    logic sclk_inv;
  } port_mode_t;
endpackage

// File: rtl/port_mode_dec.sv
module port_mode_dec
  import adc_port_pkg::*;
(
  input  logic       ser_sel_i,
  input  logic [2:0] pad_in_i,
  output port_mode_t mode_o
);
  // pad readback only means something while the pads are released
  always_comb begin
    mode_o.serial   = ser_sel_i;
    mode_o.slave    = ser_sel_i & pad_in_i[0];
    mode_o.sync_low = ser_sel_i & pad_in_i[1];
    mode_o.sclk_inv = ser_sel_i & pad_in_i[2];
  end
endmodule

// File: rtl/res_coder.sv
module res_coder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic             bin_sel_i,
  output logic [WIDTH-1:0] coded_o
);
  always_comb begin
    coded_o            = raw_i;
    coded_o[WIDTH-1]   = raw_i[WIDTH-1] ^ ~bin_sel_i;
  end
endmodule

// File: rtl/sclk_engine.sv
module sclk_engine #(
  parameter int CLK_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic inv_i,
  input  logic run_i,
  input  logic start_i,
  input  logic sclk_pin_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (start_i || !run_i || slave_i) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // external clock into the system domain
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   eff, eff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      eff_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_pin_i};
      eff_q  <= eff;
    end
  end

  assign eff = sync_q[SYNC_STAGES-1] ^ inv_i;

  logic m_rise, m_fall, s_rise, s_fall;
  assign m_rise = ~slave_i & run_i & tick & ~sclk_q;
  assign m_fall = ~slave_i & run_i & tick &  sclk_q;
  assign s_rise =  slave_i & run_i &  eff & ~eff_q;
  assign s_fall =  slave_i & run_i & ~eff &  eff_q;

  assign rise_o = m_rise | s_rise;
  assign fall_o = m_fall | s_fall;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             sdout_o
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] sreg_q;
  logic [CNT_W-1:0] bcnt_q;
  logic             busy_q, pend_q, armed_q;
  logic             step, last;

  assign start_o = en_i & ~busy_q & (valid_i | pend_q);
  assign step    = fall_i & armed_q;
  assign last    = step & (bcnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      bcnt_q  <= '0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (start_o) begin
      sreg_q  <= word_i;
      bcnt_q  <= '0;
      busy_q  <= 1'b1;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (busy_q) begin
      if (valid_i) pend_q <= 1'b1;
      if (rise_i) armed_q <= 1'b1;
      if (step) begin
        armed_q <= 1'b0;
        sreg_q  <= sreg_q << 1;
        bcnt_q  <= bcnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign sdout_o = busy_q & sreg_q[WIDTH-1];
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_port_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int ALWAYS_OUT  = 4,
  parameter int CLK_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] result_i,
  input  logic             result_valid_i,
  input  logic             ser_sel_i,
  input  logic             bin_sel_i,
  input  logic [2:0]       pad_in_i,
  input  logic             sclk_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] data_oe_o,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             sync_o,
  output logic             sdout_o
);
  port_mode_t       mode;
  logic [WIDTH-1:0] res_q, load_raw, load_word;
  logic             start, busy, rise, fall, sclk_int;

  port_mode_dec u_mode (
    .ser_sel_i (ser_sel_i),
    .pad_in_i  (pad_in_i),
    .mode_o    (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             res_q <= '0;
    else if (result_valid_i) res_q <= result_i;
  end

  res_coder #(.WIDTH(WIDTH)) u_par_coder (
    .raw_i     (res_q),
    .bin_sel_i (bin_sel_i),
    .coded_o   (data_o)
  );

  // same-cycle strobe wins over the held word
  assign load_raw = result_valid_i ? result_i : res_q;

  res_coder #(.WIDTH(WIDTH)) u_ser_coder (
    .raw_i     (load_raw),
    .bin_sel_i (bin_sel_i),
    .coded_o   (load_word)
  );

  for (genvar p = 0; p < WIDTH; p++) begin : g_pad
    if (p < ALWAYS_OUT) begin : g_fixed
      assign data_oe_o[p] = 1'b1;
    end else begin : g_shared
      assign data_oe_o[p] = ~mode.serial;
    end
  end

  frame_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode.serial),
    .valid_i (result_valid_i),
    .word_i  (load_word),
    .rise_i  (rise),
    .fall_i  (fall),
    .start_o (start),
    .busy_o  (busy),
    .sdout_o (sdout_o)
  );

  sclk_engine #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slave_i    (mode.slave),
    .inv_i      (mode.sclk_inv),
    .run_i      (busy),
    .start_i    (start),
    .sclk_pin_i (sclk_i),
    .sclk_o     (sclk_int),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  assign sclk_o    = sclk_int ^ mode.sclk_inv;
  assign sclk_oe_o = mode.serial & ~mode.slave;
  assign sync_o    = busy ^ mode.sync_low;
endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk #(
  parameter int WIDTH      = 16,
  parameter int ALWAYS_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             result_valid_i,
  input logic             ser_sel_i,
  input logic             bin_sel_i,
  input logic [2:0]       pad_in_i,
  input logic [WIDTH-1:0] data_o,
  input logic [WIDTH-1:0] data_oe_o,
  input logic             sclk_o,
  input logic             sclk_oe_o,
  input logic             sync_o,
  input logic             sdout_o
);
  a_r3_low_pins_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &data_oe_o[ALWAYS_OUT-1:0]);

  a_r3_shared_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sel_i |-> (data_oe_o[WIDTH-1:ALWAYS_OUT] == '0));

  a_r4_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_i |=> (!$stable(bin_sel_i) || $stable(data_o)));

  a_r5_master_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_sel_i && !pad_in_i[0] && (sync_o == pad_in_i[1])) |-> (sclk_o == pad_in_i[2]));

  a_r6_data_moves_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_sel_i && !pad_in_i[0] && $stable(ser_sel_i) && $stable(pad_in_i) &&
     (sync_o != pad_in_i[1]) && ($past(sync_o) != $past(pad_in_i[1])) && $stable(sclk_o))
    |-> $stable(sdout_o));

  a_r9_slave_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_sel_i && pad_in_i[0]) |-> !sclk_oe_o);

  a_r11_parallel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_sel_i |=> !sdout_o);
endmodule

bind adc_result_port adc_result_port_chk #(.WIDTH(WIDTH), .ALWAYS_OUT(ALWAYS_OUT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .result_valid_i (result_valid_i),
  .ser_sel_i      (ser_sel_i),
  .bin_sel_i      (bin_sel_i),
  .pad_in_i       (pad_in_i),
  .data_o         (data_o),
  .data_oe_o      (data_oe_o),
  .sclk_o         (sclk_o),
  .sclk_oe_o      (sclk_oe_o),
  .sync_o         (sync_o),
  .sdout_o        (sdout_o)
);

// File: tb/adc_result_port_bench.sv
module adc_result_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int DIV        = 2;
  localparam int FRAME      = 2 * DIV * W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  result_i = '0;
  logic          result_valid_i = 1'b0;
  logic          ser_sel_i = 1'b0;
  logic          bin_sel_i = 1'b1;
  logic [2:0]    pad_in_i = 3'b000;
  logic          sclk_i = 1'b0;
  logic [W-1:0]  data_o, data_oe_o;
  logic          sclk_o, sclk_oe_o, sync_o, sdout_o;

  int tests = 0;
  int fails = 0;
  bit chk_ser = 1'b1;
  bit done = 1'b0;

  adc_result_port #(.WIDTH(W), .CLK_DIV(DIV)) u_adc_result_port (
    .clk_i, .rst_ni, .result_i, .result_valid_i, .ser_sel_i, .bin_sel_i,
    .pad_in_i, .sclk_i, .data_o, .data_oe_o, .sclk_o, .sclk_oe_o, .sync_o, .sdout_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [W-1:0] code(input logic [W-1:0] v, input logic b);
    return b ? v : (v ^ 16'h8000);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int           m_t = 0;
  bit           m_busy = 1'b0, m_pend = 1'b0;
  logic [W-1:0] m_word = '0, m_res = '0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_t = 0; m_busy = 1'b0; m_pend = 1'b0; m_word = '0; m_res = '0;
    end else begin
      if (!ser_sel_i) begin
        m_busy = 1'b0; m_pend = 1'b0;
      end else if (m_busy) begin
        if (result_valid_i) m_pend = 1'b1;
        if (!pad_in_i[0]) begin
          m_t++;
          if (m_t == FRAME) m_busy = 1'b0;
        end
      end else if (result_valid_i || m_pend) begin
        m_word = code(result_valid_i ? result_i : m_res, bin_sel_i);
        m_busy = 1'b1; m_t = 0; m_pend = 1'b0;
      end
      if (result_valid_i) m_res = result_i;
    end
    #(CLK_PERIOD/4);
    if (rst_ni && !done) begin
      logic exp_sclk, exp_sd;
      check("R1/R2/R4 data_o", 32'(data_o), 32'(code(m_res, bin_sel_i)));
      check("R3 data_oe_o", 32'(data_oe_o), ser_sel_i ? 32'h000F : 32'hFFFF);
      if (chk_ser) begin
        exp_sclk = m_busy ? 1'(((m_t / DIV) % 2)) : 1'b0;
        exp_sd   = m_busy ? m_word[W-1 - m_t/(2*DIV)] : 1'b0;
        check("R6/R10 sdout_o", 32'(sdout_o), 32'(exp_sd));
        check("R7 sync_o", 32'(sync_o), 32'(m_busy ^ (ser_sel_i & pad_in_i[1])));
        check("R5/R8 sclk_o", 32'(sclk_o), 32'(exp_sclk ^ (ser_sel_i & pad_in_i[2])));
        check("R5 sclk_oe_o", 32'(sclk_oe_o), 32'(ser_sel_i & ~pad_in_i[0]));
      end
    end
  end

  task automatic strobe(input logic [W-1:0] v);
    @(negedge clk_i);
    result_i = v; result_valid_i = 1'b1;
    @(negedge clk_i);
    result_valid_i = 1'b0;
  endtask

  task automatic slave_frame(input logic [W-1:0] v, input logic inv, input string tag);
    logic [W-1:0] w;
    w = code(v, bin_sel_i);
    strobe(v);
    for (int i = 0; i < W; i++) begin
      check({tag, " slave bit"}, 32'(sdout_o), 32'(w[W-1-i]));
      check({tag, " slave sclk_oe_o"}, 32'(sclk_oe_o), 32'h0);
      sclk_i = ~inv;
      repeat (5) @(negedge clk_i);
      sclk_i = inv;
      repeat (5) @(negedge clk_i);
    end
    check({tag, " slave frame end"}, 32'(sync_o), 32'(pad_in_i[1]));
    check({tag, " slave idle data"}, 32'(sdout_o), 32'h0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 reset data_o", 32'(data_o), 32'h0);
    check("R3 reset data_oe_o", 32'(data_oe_o), 32'hFFFF);
    check("R7 reset sync_o", 32'(sync_o), 32'h0);
    check("R6 reset sdout_o", 32'(sdout_o), 32'h0);

    // parallel
    strobe(16'h1234);
    check("R2 parallel word", 32'(data_o), 32'h1234);
    bin_sel_i = 1'b0; #1;
    check("R1 twos complement", 32'(data_o), 32'h9234);
    result_i = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    check("R4 hold without strobe", 32'(data_o), 32'h9234);
    bin_sel_i = 1'b1;

    // master, plain polarities
    ser_sel_i = 1'b1; pad_in_i = 3'b000;
    repeat (2) @(negedge clk_i);
    strobe(16'hA5C3);
    repeat (FRAME + 4) @(negedge clk_i);
    check("R7 idle after frame", 32'(sync_o), 32'h0);

    // inverted polarities, two's complement, mid-frame strobe
    pad_in_i = 3'b110; bin_sel_i = 1'b0;
    repeat (2) @(negedge clk_i);
    strobe(16'h7FFE);
    repeat (20) @(negedge clk_i);
    strobe(16'h0001);
    repeat (2 * FRAME + 10) @(negedge clk_i);

    // strobe on the closing edge
    pad_in_i = 3'b010; bin_sel_i = 1'b1;
    strobe(16'h8001);
    repeat (FRAME - 2) @(negedge clk_i);
    strobe(16'h6B2D);
    repeat (2 * FRAME + 10) @(negedge clk_i);
    check("R10 both frames done", 32'(sync_o), 32'h1);

    // abort on mode drop
    pad_in_i = 3'b000;
    strobe(16'hFFFF);
    repeat (20) @(negedge clk_i);
    ser_sel_i = 1'b0;
    @(negedge clk_i);
    check("R11 abort data", 32'(sdout_o), 32'h0);
    check("R11 abort sync", 32'(sync_o), 32'h0);
    ser_sel_i = 1'b1;
    repeat (10) @(negedge clk_i);
    check("R11 nothing pending", 32'(sync_o), 32'h0);

    // slave
    chk_ser = 1'b0;
    pad_in_i = 3'b001; sclk_i = 1'b0;
    repeat (5) @(negedge clk_i);
    slave_frame(16'hC35A, 1'b0, "R9");
    pad_in_i = 3'b101; sclk_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R8 slave inverted idle sclk_o", 32'(sclk_o), 32'h1);
    slave_frame(16'h3C96, 1'b1, "R8/R9");

    finish_run();
  end
endmodule